// File: doc/BRIEF.md
# Multi-Lane Parallel PRBS31 Generator

This block produces a maximal-length pseudo-random bit stream of period 2^31-1 for several output lanes at once. A single 31-bit linear feedback shift register is advanced four serial steps per slow clock through unrolled next-state logic. This yields four quarter-rate sub-sequences, where sub-sequence k carries serial bits 4n+k. The four bits are collected into a 4-bit word per slow clock. A 4:1 serializer on a clock running at four times the slow rate turns that word back into the full-rate serial stream.

Extra lanes are not built from separate generators. Each lane past the first is the same four sub-sequences, passed through a whole number of slow-clock delay stages and then interleaved again. Lane L is therefore the lane 0 sequence shifted by 4·L·OFFSET_STEP bits, which gives every lane a mutually shifted copy of the same sequence. The sequence can be restarted from any seed. Holding enable low freezes the generator state, the delay stages and the parallel words.

Top module: `prbsMultiLane`

## Requirements
- R1: While `rst` is high at a slow-clock edge, the generator state becomes the default seed 31'h7FFFFFFF, every parallel lane word becomes 0, and every serial output reads 0.
- R2: The generator uses x^31 + x^28 + 1. Serial step n outputs state bit 30 and shifts state bit 30 XOR state bit 27 into bit 0. At each slow edge with `en` high and `seedLoad` low, lane 0's word advances so that bit k equals serial bit 4n+k. The new word is visible right after that edge.
- R3: `clkFast` runs at four times `clk`, with rising edges aligned. Each lane's serial output sends, in the slow cycle after a word is registered, that word's bits in order: bit 0 first, then bits 1, 2 and 3, one bit per fast cycle.
- R4: The word on lane L (bits 4L+3..4L of `laneWord`) equals the lane 0 word from L·OFFSET_STEP enabled slow cycles earlier. This is the lane 0 bit stream delayed by 4·L·OFFSET_STEP bits.
- R5: A slow edge with `seedLoad` high replaces the state with `seedIn`, whatever the value of `en`. On that edge the parallel words and delay stages hold. The next enabled edge presents the first four bits generated from the new seed.
- R6: Loading an all-zero seed installs the default seed 31'h7FFFFFFF instead.
- R7: With `en` low and `seedLoad` low, the state, delay stages and parallel words hold. Each serial output keeps repeating its held word.
- R8: The generator state is never all-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow (word-rate) clock |
| clkFast | input | 1 | Bit-rate clock, four times `clk`, rising edges aligned |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable |
| seedLoad | input | 1 | Replace generator state with `seedIn` |
| seedIn | input | 31 | Seed value |
| laneWord | output | LANES*4 | Parallel 4-bit word per lane, lane 0 in the low nibble |
| laneSerial | output | LANES | Full-rate serial bit per lane |

## Verification
The assertions assume that `rst` is high at the first slow edge. They also assume that `en`, `seedLoad` and `seedIn` change only between slow edges, and that `clkFast` is an aligned 4x clock, so that the serializer phase lines up with each slow edge. The bench builds both clocks from one timing loop. It changes every input one nanosecond before a slow edge and samples one nanosecond after fast edges. Lane and serial comparisons are made only once enough enabled cycles have passed since the last reset or seed load to fill the relevant delay stages.

// File: rtl/prbsPkg.sv
package prbsPkg;
  localparam int REG_W = 31;
  localparam int SUB_N = 4;
  localparam int TAP_HI = REG_W - 1;
  localparam int TAP_LO = 27;
  localparam logic [REG_W-1:0] DEFAULT_SEED = 31'h7FFF_FFFF;

  typedef struct packed {
    logic reseed;
    logic useDefault;
    logic advance;
  } prbsStrobe_t;
endpackage

// File: rtl/prbsCtrl.sv
module prbsCtrl
  import prbsPkg::*;
(
  input  logic             rst,
  input  logic             en,
  input  logic             seedLoad,
  input  logic [REG_W-1:0] seedIn,
  output prbsStrobe_t      strobe
);
  always_comb begin
    strobe.reseed     = rst | seedLoad;
    strobe.useDefault = rst | (seedIn == '0);
    strobe.advance    = en & ~seedLoad & ~rst;
  end
endmodule

// File: rtl/prbsDatapath.sv
module prbsDatapath
  import prbsPkg::*;
#(
  parameter int LANES       = 3,
  parameter int OFFSET_STEP = 3
) (
  input  logic                   clk,
  input  logic                   clkFast,
  input  logic                   rst,
  input  prbsStrobe_t            strobe,
  input  logic [REG_W-1:0]       seedIn,
  output logic [LANES*SUB_N-1:0] laneWord,
  output logic [LANES-1:0]       laneSerial,
  output logic [REG_W-1:0]       stateNow
);
  localparam int PH_W = $clog2(SUB_N);

  logic [REG_W-1:0] lfsrState;
  logic [REG_W-1:0] nextState;
  logic [SUB_N-1:0] nextWord;
  logic [SUB_N-1:0] wordReg;
  logic [SUB_N-1:0] laneW [LANES];
  logic [PH_W-1:0]  phase;

  // Four serial steps unrolled; sub-sequence k taps the output of step k.
  always_comb begin
    logic [REG_W-1:0] s;
    s = lfsrState;
    for (int k = 0; k < SUB_N; k++) begin
      nextWord[k] = s[TAP_HI];
      s = {s[REG_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
    end
    nextState = s;
  end

  always_ff @(posedge clk) begin
    if (strobe.reseed)
      lfsrState <= strobe.useDefault ? DEFAULT_SEED : seedIn;
    else if (strobe.advance)
      lfsrState <= nextState;
  end

  always_ff @(posedge clk) begin
    if (rst)
      wordReg <= '0;
    else if (strobe.advance)
      wordReg <= nextWord;
  end

  assign stateNow = lfsrState;

  always_ff @(posedge clkFast) begin
    if (rst) phase <= '0;
    else     phase <= phase + 1'b1;
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam int DEPTH = L * OFFSET_STEP;
    logic [SUB_N-1:0] shReg;

    if (DEPTH == 0) begin : g_direct
      assign laneW[L] = wordReg;
    end else begin : g_delay
      logic [SUB_N-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else if (strobe.advance) begin
          stage[0] <= wordReg;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign laneW[L] = stage[DEPTH-1];
    end

    always_ff @(posedge clkFast) begin
      if (rst)
        shReg <= '0;
      else if (phase == '0)
        shReg <= laneW[L];
      else
        shReg <= shReg >> 1;
    end

    assign laneWord[L*SUB_N +: SUB_N] = laneW[L];
    assign laneSerial[L] = shReg[0];
  end
endmodule

// File: rtl/prbsMultiLane.sv
module prbsMultiLane
  import prbsPkg::*;
#(
  parameter int LANES       = 3,
  parameter int OFFSET_STEP = 3
) (
  input  logic                   clk,
  input  logic                   clkFast,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   seedLoad,
  input  logic [30:0]            seedIn,
  output logic [LANES*4-1:0]     laneWord,
  output logic [LANES-1:0]       laneSerial
);
  prbsStrobe_t      strobe;
  logic [REG_W-1:0] stateNow;

  prbsCtrl u_ctrl (
    .rst      (rst),
    .en       (en),
    .seedLoad (seedLoad),
    .seedIn   (seedIn),
    .strobe   (strobe)
  );

  prbsDatapath #(.LANES(LANES), .OFFSET_STEP(OFFSET_STEP)) u_dp (
    .clk        (clk),
    .clkFast    (clkFast),
    .rst        (rst),
    .strobe     (strobe),
    .seedIn     (seedIn),
    .laneWord   (laneWord),
    .laneSerial (laneSerial),
    .stateNow   (stateNow)
  );
endmodule

// File: rtl/prbsMultiLaneChk.sv
module prbsMultiLaneChk
  import prbsPkg::*;
#(
  parameter int LANES = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   en,
  input logic                   seedLoad,
  input logic [REG_W-1:0]       seedIn,
  input logic [LANES*SUB_N-1:0] laneWord,
  input logic [REG_W-1:0]       stateNow
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (stateNow == DEFAULT_SEED) && (laneWord == '0));

  // R2
  advance_word_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !seedLoad) |=> laneWord[SUB_N-1:0] ==
      {$past(stateNow[27]), $past(stateNow[28]), $past(stateNow[29]), $past(stateNow[30])});

  // R5
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedIn != '0) |=> (stateNow == $past(seedIn)) && $stable(laneWord));

  // R6
  zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (seedLoad && seedIn == '0) |=> stateNow == DEFAULT_SEED);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !seedLoad) |=> $stable(stateNow) && $stable(laneWord));

  // R8
  nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
    stateNow != '0);
endmodule

bind prbsMultiLane prbsMultiLaneChk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .seedLoad (seedLoad),
  .seedIn   (seedIn),
  .laneWord (laneWord),
  .stateNow (stateNow)
);

// File: tb/prbsMultiLane_tb.sv
module prbsMultiLane_tb;
  localparam int LANES = 3;
  localparam int STEP  = 3;
  localparam logic [30:0] DEF = 31'h7FFF_FFFF;
  // {seed, expected first word}
  localparam logic [34:0] VEC [5] = '{
    {31'h4000_0000, 4'b0001},
    {31'h0800_0000, 4'b1000},
    {31'h3000_0000, 4'b0110},
    {31'h0000_0000, 4'b1111},
    {31'h1234_5678, 4'b0100}
  };

  logic clk = 0, clkFast = 0;
  logic rst = 1, en = 0, seedLoad = 0;
  logic [30:0] seedIn = '0;
  logic [LANES*4-1:0] laneWord;
  logic [LANES-1:0] laneSerial;

  int errors = 0, checks = 0;
  logic [3:0] hist [0:255];
  logic [3:0] dutHist [0:255];
  int k = 0;
  logic [30:0] refState;
  logic [LANES*4-1:0] lw, lwPrev;
  logic [3:0] serS [LANES];

  prbsMultiLane #(.LANES(LANES), .OFFSET_STEP(STEP)) u_dut (
    .clk(clk), .clkFast(clkFast), .rst(rst), .en(en), .seedLoad(seedLoad),
    .seedIn(seedIn), .laneWord(laneWord), .laneSerial(laneSerial)
  );

  // 125 MHz slow clock, 500 MHz aligned fast clock
  initial begin
    bit ph = 0;
    forever begin
      #1 clkFast = ~clkFast;
      if (clkFast) begin
        if (!ph) clk = ~clk;
        ph = ~ph;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] refWord(input logic [30:0] s);
    logic [3:0] w;
    for (int i = 0; i < 4; i++) begin
      w[i] = s[30];
      s = {s[29:0], s[30] ^ s[27]};
    end
    return w;
  endfunction

  function automatic logic [30:0] refAdv(input logic [30:0] s);
    for (int i = 0; i < 4; i++) s = {s[29:0], s[30] ^ s[27]};
    return s;
  endfunction

  // one slow cycle: sample parallel at E+1, serial bits at E+1,3,5,7
  task automatic tick();
    lwPrev = lw;
    @(posedge clk);
    #1;
    lw = laneWord;
    for (int j = 0; j < 4; j++) begin
      if (j > 0) #2;
      for (int L = 0; L < LANES; L++) serS[L][j] = laneSerial[L];
    end
  endtask

  task automatic runEn(int n);
    en = 1;
    for (int c = 0; c < n; c++) begin
      tick();
      hist[k] = refWord(refState);
      refState = refAdv(refState);
      dutHist[k] = lw[3:0];
      k++;
      chk("R2 lane0 word", {28'd0, lw[3:0]}, {28'd0, hist[k-1]});
      for (int L = 0; L < LANES; L++) begin
        if (L > 0 && k - 1 - L*STEP >= 0) begin
          chk("R4 lane vs ref", {28'd0, lw[L*4 +: 4]}, {28'd0, hist[k-1-L*STEP]});
          chk("R4 lane vs lane0 shift", {28'd0, lw[L*4 +: 4]}, {28'd0, dutHist[k-1-L*STEP]});
        end
        if (k - 2 - L*STEP >= 0)
          chk("R3 serial order", {28'd0, serS[L]}, {28'd0, hist[k-2-L*STEP]});
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset
    for (int c = 0; c < 3; c++) tick();
    chk("R1 words zero", {20'd0, lw}, 32'd0);
    chk("R1 serial zero", {28'd0, serS[0] | serS[1] | serS[2]}, 32'd0);
    rst = 0;
    refState = DEF;
    k = 0;
    runEn(30);

    // R7 hold: words frozen, serial repeats held word
    en = 0;
    for (int c = 0; c < 4; c++) begin
      tick();
      chk("R7 words hold", {20'd0, lw}, {20'd0, lwPrev});
      chk("R7 serial repeats", {28'd0, serS[0]}, {28'd0, hist[k-1]});
    end
    runEn(10);

    // table of seeds: R5 load and R6 zero seed
    for (int v = 0; v < 5; v++) begin
      seedIn = VEC[v][34:4];
      seedLoad = 1;
      en = 1;
      tick();
      chk("R5 load holds words", {20'd0, lw}, {20'd0, lwPrev});
      seedLoad = 0;
      k = 0;
      refState = (VEC[v][34:4] == '0) ? DEF : VEC[v][34:4];
      runEn(1);
      // R6/R8: zero seed entry expects default-seed output
      chk("R5/R6 first word", {28'd0, lw[3:0]}, {28'd0, VEC[v][3:0]});
      runEn(24);
    end

    // R5 load with enable low, then resume
    en = 0;
    seedIn = 31'h0000_0001;
    seedLoad = 1;
    tick();
    chk("R5 load en low holds", {20'd0, lw}, {20'd0, lwPrev});
    seedLoad = 0;
    k = 0;
    refState = 31'h0000_0001;
    runEn(40);

    // R1 reset in mid-run
    rst = 1;
    en = 1;
    tick();
    tick();
    chk("R1 mid-run words zero", {20'd0, lw}, 32'd0);
    chk("R1 mid-run serial zero", {28'd0, serS[0] | serS[1] | serS[2]}, 32'd0);
    rst = 0;
    k = 0;
    refState = DEF;
    runEn(20);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule